// File: doc/BRIEF.md
# Rail Window Fault Qualifier

This block supervises one supply rail from a stream of digital voltage codes, typically the results of an ADC. Every accepted code is compared against a lower and an upper trip level. A code below the lower level is an undervoltage candidate, and a code above the upper level is an overvoltage candidate. A candidate only becomes a fault once it has lasted for a programmable blanking time. This keeps short spikes and ripple from tripping the supervisor.

After a fault, the rail is good again only when it has returned inside a narrower window. Each threshold is pulled inward by its own hysteresis amount, and the rail must then stay there for the same blanking time. This two-sided hysteresis stops chatter on slow ramps. The block drives a qualified power-good flag and a two-bit cause code.

Blanking is counted in ticks of a 1 µs timebase. The timebase is derived from the clock by a divide-by-`TICK_DIV` prescaler. The prescaler and the tick counter restart whenever the pending condition goes away. A small write port sets the thresholds, the hysteresis amounts and the blanking length.

Top module: `rail_window_qualifier`

## Requirements
- R1: While `rst_n` is low, `power_good` is 0 and `fault_cause` is 2'b00 (none).
- R2: After reset, `power_good` rises only after the held code has been inside the narrowed window for B consecutive clock cycles, where B = blank × `TICK_DIV`. The narrowed window is lower + hyst_lo ≤ code ≤ upper − hyst_hi.
- R3: While good, a code strictly below the lower level held for B cycles drops `power_good` and sets `fault_cause` to 2'b01 (undervoltage).
- R4: While good, a code strictly above the upper level held for B cycles drops `power_good` and sets `fault_cause` to 2'b10 (overvoltage). The value 2'b11 never appears.
- R5: An out-of-window excursion that lasts fewer than B cycles leaves `power_good` high.
- R6: The blanking count restarts whenever the code returns to the window before the count expires. Two sub-B excursions separated by one in-window cycle therefore raise no fault.
- R7: After an undervoltage fault, a code at or above the lower level but below lower + hyst_lo keeps `power_good` low.
- R8: After an overvoltage fault, a code at or below the upper level but above upper − hyst_hi keeps `power_good` low.
- R9: While good, codes exactly equal to the lower or the upper level count as in window.
- R10: `fault_cause` holds the type of the qualified fault while `power_good` is low. It returns to 2'b00 on the same edge at which `power_good` is regained.
- R11: A write with `cfg_we` high stores `cfg_wdata` into the register that `cfg_sel` selects. The select codes are 0 for the lower level, 1 for the upper level, 2 for hyst_lo, 3 for hyst_hi and 4 for blank (6-bit, taken from bits [5:0]). The new value governs qualification from the next cycle.
- R12: With blank = 0, a condition present for a single cycle is qualified.
- R13: `sample_code` is captured only in cycles where `sample_valid` is high. Otherwise the previous code stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Qualifies `sample_code` |
| sample_code | input | CODE_W | Rail voltage code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (see R11) |
| cfg_wdata | input | CODE_W | Configuration write data |
| power_good | output | 1 | Qualified rail-good flag |
| fault_cause | output | 2 | 00 none, 01 undervoltage, 10 overvoltage |

## Verification
The hardest condition to reach from the ports is the hysteresis band after a fault. In that band the code is already back inside the plain window, so a single compare would release the rail, yet the rail must stay faulted. The stimulus first qualifies a real undervoltage or overvoltage fault. It then parks the code one step inside each trip level, and one step short of the narrowed edge, for longer than the blanking time. Counter restart is reached by two excursions of B−1 cycles split by one in-window cycle. The exact boundary is hit by holding a code for B−1 and for B cycles.

// File: rtl/rail_window_qualifier.sv
module rail_window_qualifier #(
  parameter int CODE_W   = 12,
  parameter int BLANK_W  = 6,
  parameter int TICK_DIV = 125,
  parameter int SEL_W    = 3,
  parameter logic [CODE_W-1:0]  RST_LOWER   = 12'd1860,
  parameter logic [CODE_W-1:0]  RST_UPPER   = 12'd2140,
  parameter logic [CODE_W-1:0]  RST_HYST_LO = 12'd40,
  parameter logic [CODE_W-1:0]  RST_HYST_HI = 12'd40,
  parameter logic [BLANK_W-1:0] RST_BLANK   = 6'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] sample_code,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CODE_W-1:0] cfg_wdata,
  output logic              power_good,
  output logic [1:0]        fault_cause
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int EXT_W = CODE_W + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_UV   = 2'b01;
  localparam logic [1:0] CAUSE_OV   = 2'b10;

  logic [CODE_W-1:0]  lower_q, upper_q, hyst_lo_q, hyst_hi_q, samp_q;
  logic [BLANK_W-1:0] blank_q, cnt_q;
  logic [PRE_W-1:0]   pre_q;
  logic               pg_q;
  logic [1:0]         cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lower_q   <= RST_LOWER;
      upper_q   <= RST_UPPER;
      hyst_lo_q <= RST_HYST_LO;
      hyst_hi_q <= RST_HYST_HI;
      blank_q   <= RST_BLANK;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_W'(0): lower_q   <= cfg_wdata;
        SEL_W'(1): upper_q   <= cfg_wdata;
        SEL_W'(2): hyst_lo_q <= cfg_wdata;
        SEL_W'(3): hyst_hi_q <= cfg_wdata;
        SEL_W'(4): blank_q   <= cfg_wdata[BLANK_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            samp_q <= '0;
    else if (sample_valid) samp_q <= sample_code;
  end

  wire below_lo = samp_q < lower_q;
  wire above_hi = samp_q > upper_q;
  wire clear_lo = {1'b0, samp_q} >= ({1'b0, lower_q} + {1'b0, hyst_lo_q});
  wire clear_hi = ({1'b0, samp_q} + {1'b0, hyst_hi_q}) <= EXT_W'({1'b0, upper_q});

  wire pend      = pg_q ? (below_lo | above_hi) : (clear_lo & clear_hi);
  wire last_tick = pre_q == PRE_LAST;
  wire expire    = pend & ((blank_q == '0) | (last_tick & (cnt_q == blank_q - 1'b1)));

  always_ff @(posedge clk) begin
    if (!rst_n || !pend || expire) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (last_tick) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_q    <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (expire) begin
      pg_q    <= !pg_q;
      cause_q <= pg_q ? (below_lo ? CAUSE_UV : CAUSE_OV) : CAUSE_NONE;
    end
  end

  assign power_good  = pg_q;
  assign fault_cause = cause_q;
endmodule

// File: rtl/rail_window_qualifier_chk.sv
module rail_window_qualifier_chk #(
  parameter int PRE_W    = 7,
  parameter int TICK_DIV = 125
) (
  input logic             clk,
  input logic             rst_n,
  input logic             power_good,
  input logic [1:0]       fault_cause,
  input logic [PRE_W-1:0] pre_q
);
  assert_fall_sets_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_good) |-> fault_cause != 2'b00);

  assert_no_illegal_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cause != 2'b11);

  assert_good_means_no_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    power_good |-> fault_cause == 2'b00);

  assert_cause_moves_only_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(fault_cause) && fault_cause != 2'b00) |-> $fell(power_good));

  assert_prescale_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_q) < TICK_DIV);
endmodule

bind rail_window_qualifier rail_window_qualifier_chk #(.PRE_W(PRE_W), .TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .power_good(power_good),
  .fault_cause(fault_cause),
  .pre_q(pre_q)
);

// File: tb/rail_window_qualifier_bench.sv
module rail_window_qualifier_bench;
  localparam int TD = 4;
  localparam int B  = 10 * TD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b1;
  logic [11:0] sample_code = 12'd2000;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [11:0] cfg_wdata = '0;
  logic        power_good;
  logic [1:0]  fault_cause;

  always #4 clk = ~clk;

  rail_window_qualifier #(.TICK_DIV(TD)) u_rail_window_qualifier (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_code(sample_code),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .power_good(power_good), .fault_cause(fault_cause)
  );

  typedef struct {
    logic       pg;
    logic [1:0] cause;
    string      tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  task automatic expect_out(input logic pg, input logic [1:0] cause, input string tag);
    exp_t e;
    e.pg = pg; e.cause = cause; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(input logic [11:0] code, input int n, input logic valid = 1'b1);
    sample_code  = code;
    sample_valid = valid;
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [11:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (power_good !== e.pg || fault_cause !== e.cause) begin
          miscompares++;
          $display("FAIL %s: pg=%0b cause=%0d expected pg=%0b cause=%0d",
                   e.tag, power_good, fault_cause, e.pg, e.cause);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    expect_out(1'b0, 2'b00, "R1 reset state");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    drive(12'd2000, B - 1);
    expect_out(1'b0, 2'b00, "R2 not yet good at B-1");
    drive(12'd2000, 1);
    expect_out(1'b1, 2'b00, "R2 good after B");
    drive(12'd1800, B - 1);
    expect_out(1'b1, 2'b00, "R5 short undervoltage rejected");
    drive(12'd2000, 1);
    drive(12'd2300, B - 1);
    expect_out(1'b1, 2'b00, "R5 short overvoltage rejected");
    drive(12'd2000, 1);
    drive(12'd1800, B - 1);
    drive(12'd2000, 1);
    drive(12'd1800, B - 1);
    expect_out(1'b1, 2'b00, "R6 count restarts");
    drive(12'd2000, 5);
    drive(12'd1860, B + 5);
    expect_out(1'b1, 2'b00, "R9 lower level in window");
    drive(12'd2140, B + 5);
    expect_out(1'b1, 2'b00, "R9 upper level in window");
    drive(12'd1859, B);
    expect_out(1'b0, 2'b01, "R3 undervoltage qualified");
    drive(12'd1880, B + 5);
    expect_out(1'b0, 2'b01, "R7 inside hysteresis stays low");
    drive(12'd1899, B + 5);
    expect_out(1'b0, 2'b01, "R10 cause held while low");
    drive(12'd1900, B);
    expect_out(1'b1, 2'b00, "R10 regained clears cause");
    drive(12'd2141, B);
    expect_out(1'b0, 2'b10, "R4 overvoltage qualified");
    drive(12'd2101, B + 5);
    expect_out(1'b0, 2'b10, "R8 inside hysteresis stays low");
    drive(12'd2100, B);
    expect_out(1'b1, 2'b00, "R8 recovery at narrowed edge");
    cfg_write(3'd4, 12'd3);
    cfg_write(3'd0, 12'd1500);
    drive(12'd1600, 20);
    expect_out(1'b1, 2'b00, "R11 new lower level");
    drive(12'd1499, 3 * TD);
    expect_out(1'b0, 2'b01, "R11 new blank length");
    drive(12'd1540, 3 * TD);
    expect_out(1'b1, 2'b00, "R11 recovery with new values");
    cfg_write(3'd4, 12'd0);
    drive(12'd1499, 1);
    expect_out(1'b0, 2'b01, "R12 zero blank one cycle");
    drive(12'd2000, 1);
    expect_out(1'b1, 2'b00, "R12 zero blank recovery");
    drive(12'd1000, 20, 1'b0);
    expect_out(1'b1, 2'b00, "R13 invalid sample ignored");
    drive(12'd2000, 3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule